// File: doc/BRIEF.md
# Packet Round-Robin Stream Merger

This block combines three packet streams into a single outgoing stream. Two of the inputs carry traffic from physical Ethernet ports. The third carries traffic from the host DMA path. Each input lands in its own small first-word-fall-through queue. A rotating selector then chooses a queue that holds data and sends one complete packet from it before any other input may use the output. Packets from different inputs are therefore never mixed on the output.

Every beat carries data, a byte-enable field, a packet-end flag and a side-band user field. The user field identifies the source port. The block copies all of these from input to output without change. Backpressure works at both edges. A full input queue refuses new beats. A stalled output keeps its beat on the bus until that beat is taken.

Top module: `pkt_rr_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `outValid` is low and every `inReady` bit is high.
- R2: Each input queue holds up to `DEPTH` beats (16 by default). `inReady[i]` is low exactly when queue i holds `DEPTH` beats. A beat offered while `inReady[i]` is low is not stored.
- R3: `outValid` is high only when the selected queue holds at least one beat. When all queues are empty, `outValid` is low.
- R4: From the first beat of a packet until the beat with `outLast` high is accepted, every output beat comes from the same input. Packets never interleave.
- R5: After the last beat of a packet from input i is accepted (`outValid`, `outReady` and `outLast` all high), the next packet is taken from the first non-empty queue in the order i+1, i+2, ..., wrapping modulo 3 and ending with i itself. Empty queues are skipped.
- R6: While `outValid` is high and `outReady` is low, the next cycle keeps `outValid` high and keeps `outData`, `outKeep`, `outUser` and `outLast` unchanged.
- R7: Each input's beats appear on the output in the order they were accepted. `data`, `keep`, `user` and `last` are unchanged. In the bench, bits [1:0] of the user field carry the input index.
- R8: A beat accepted into an empty queue whose input is next in line can appear on the output one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | NUM_IN x DATA_W | Per-input beat data |
| inKeep | input | NUM_IN x DATA_W/8 | Per-input byte enables |
| inUser | input | NUM_IN x USER_W | Per-input side-band (source port) |
| inLast | input | NUM_IN | Per-input end-of-packet flag |
| inValid | input | NUM_IN | Per-input beat valid |
| inReady | output | NUM_IN | Per-input queue can accept a beat |
| outData | output | DATA_W | Merged beat data |
| outKeep | output | DATA_W/8 | Merged byte enables |
| outUser | output | USER_W | Merged side-band |
| outLast | output | 1 | Merged end-of-packet flag |
| outValid | output | 1 | Merged beat valid |
| outReady | input | 1 | Downstream accepts the beat |

## Verification
The bench first feeds a single packet into an idle block. This shows the one-cycle fall-through latency. Next, all three inputs send multi-beat packets of different lengths at the same time, with gaps between beats. That case separates true packet-level rotation from beat-level switching or a fixed priority. A run with only the first and last inputs active shows whether empty queues are skipped and whether the rotation wraps correctly. Random output stalls, and a long full stall that fills every queue, test the hold-stable rule and the refusal of beats by a full queue.

// File: rtl/pkt_rr_pkg.sv
package pkt_rr_pkg;
  // widest selector the strobe struct can carry (up to 16 inputs)
  localparam int unsigned SEL_W = 4;

  typedef struct packed {
    logic [SEL_W-1:0] sel;   // queue currently driving the output
    logic             fire;  // output beat accepted this cycle
  } arb_strobe_t;
endpackage

// File: rtl/pkt_fwft_queue.sv
module pkt_fwft_queue #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 8,
  parameter int unsigned USER_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  input  logic [KEEP_W-1:0] wrKeep,
  input  logic [USER_W-1:0] wrUser,
  input  logic              wrLast,
  input  logic              rdPop,
  output logic              notEmpty,
  output logic [DATA_W-1:0] headData,
  output logic [KEEP_W-1:0] headKeep,
  output logic [USER_W-1:0] headUser,
  output logic              headLast
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] memData [DEPTH];
  logic [KEEP_W-1:0] memKeep [DEPTH];
  logic [USER_W-1:0] memUser [DEPTH];
  logic              memLast [DEPTH];

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doWr, doRd;

  assign wrReady  = (count != CW'(DEPTH));
  assign notEmpty = (count != '0);
  assign doWr     = wrValid & wrReady;
  assign doRd     = rdPop & notEmpty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      case ({doWr, doRd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) begin
      memData[wrPtr] <= wrData;
      memKeep[wrPtr] <= wrKeep;
      memUser[wrPtr] <= wrUser;
      memLast[wrPtr] <= wrLast;
    end
  end

  assign headData = memData[rdPtr];
  assign headKeep = memKeep[rdPtr];
  assign headUser = memUser[rdPtr];
  assign headLast = memLast[rdPtr];
endmodule

// File: rtl/pkt_rr_datapath.sv
module pkt_rr_datapath
  import pkt_rr_pkg::*;
#(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned USER_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_IN-1:0][DATA_W-1:0]    inData,
  input  logic [NUM_IN-1:0][DATA_W/8-1:0]  inKeep,
  input  logic [NUM_IN-1:0][USER_W-1:0]    inUser,
  input  logic [NUM_IN-1:0]                inLast,
  input  logic [NUM_IN-1:0]                inValid,
  output logic [NUM_IN-1:0]                inReady,
  input  arb_strobe_t                      strobe,
  output logic [NUM_IN-1:0]                qNotEmpty,
  output logic [DATA_W-1:0]                outData,
  output logic [DATA_W/8-1:0]              outKeep,
  output logic [USER_W-1:0]                outUser,
  output logic                             outLast
);
  localparam int unsigned KEEP_W = DATA_W / 8;
  localparam int unsigned IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [DATA_W-1:0] headData [NUM_IN];
  logic [KEEP_W-1:0] headKeep [NUM_IN];
  logic [USER_W-1:0] headUser [NUM_IN];
  logic              headLast [NUM_IN];
  logic [NUM_IN-1:0] popVec;
  logic [IDX_W-1:0]  selIdx;

  assign selIdx = strobe.sel[IDX_W-1:0];

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_queue
    assign popVec[gi] = strobe.fire && (selIdx == IDX_W'(gi));

    pkt_fwft_queue #(
      .DATA_W(DATA_W), .KEEP_W(KEEP_W), .USER_W(USER_W), .DEPTH(DEPTH)
    ) u_queue (
      .clk      (clk),
      .rstN     (rstN),
      .wrValid  (inValid[gi]),
      .wrReady  (inReady[gi]),
      .wrData   (inData[gi]),
      .wrKeep   (inKeep[gi]),
      .wrUser   (inUser[gi]),
      .wrLast   (inLast[gi]),
      .rdPop    (popVec[gi]),
      .notEmpty (qNotEmpty[gi]),
      .headData (headData[gi]),
      .headKeep (headKeep[gi]),
      .headUser (headUser[gi]),
      .headLast (headLast[gi])
    );
  end

  always_comb begin
    outData = headData[selIdx];
    outKeep = headKeep[selIdx];
    outUser = headUser[selIdx];
    outLast = headLast[selIdx];
  end
endmodule

// File: rtl/pkt_rr_ctrl.sv
module pkt_rr_ctrl
  import pkt_rr_pkg::*;
#(
  parameter int unsigned NUM_IN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] qNotEmpty,
  input  logic              headLast,
  input  logic              outReady,
  output logic              outValid,
  output arb_strobe_t       strobe
);
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [IDX_W-1:0] ptr, lockIdx, pickIdx, selIdx;
  logic             locked, pickHit, fire;

  // first non-empty queue at or after ptr, in rotating order
  always_comb begin
    int c;
    pickIdx = ptr;
    pickHit = 1'b0;
    for (int k = NUM_IN - 1; k >= 0; k--) begin
      c = int'(ptr) + k;
      if (c >= int'(NUM_IN)) c = c - int'(NUM_IN);
      if (qNotEmpty[c[IDX_W-1:0]]) begin
        pickIdx = c[IDX_W-1:0];
        pickHit = 1'b1;
      end
    end
  end

  assign selIdx   = locked ? lockIdx : pickIdx;
  assign outValid = locked ? qNotEmpty[lockIdx] : pickHit;
  assign fire     = outValid & outReady;

  assign strobe.sel  = SEL_W'(selIdx);
  assign strobe.fire = fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      lockIdx <= '0;
      ptr     <= '0;
    end else if (fire && headLast) begin
      locked <= 1'b0;
      ptr    <= (selIdx == IDX_W'(NUM_IN - 1)) ? '0 : selIdx + IDX_W'(1);
    end else if (outValid) begin
      locked  <= 1'b1;
      lockIdx <= selIdx;
    end
  end
endmodule

// File: rtl/pkt_rr_arbiter.sv
module pkt_rr_arbiter
  import pkt_rr_pkg::*;
#(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned USER_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_IN-1:0][DATA_W-1:0]   inData,
  input  logic [NUM_IN-1:0][DATA_W/8-1:0] inKeep,
  input  logic [NUM_IN-1:0][USER_W-1:0]   inUser,
  input  logic [NUM_IN-1:0]               inLast,
  input  logic [NUM_IN-1:0]               inValid,
  output logic [NUM_IN-1:0]               inReady,
  output logic [DATA_W-1:0]               outData,
  output logic [DATA_W/8-1:0]             outKeep,
  output logic [USER_W-1:0]               outUser,
  output logic                            outLast,
  output logic                            outValid,
  input  logic                            outReady
);
  arb_strobe_t       strobe;
  logic [NUM_IN-1:0] qNotEmpty;

  pkt_rr_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .qNotEmpty (qNotEmpty),
    .headLast  (outLast),
    .outReady  (outReady),
    .outValid  (outValid),
    .strobe    (strobe)
  );

  pkt_rr_datapath #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .USER_W(USER_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .inKeep    (inKeep),
    .inUser    (inUser),
    .inLast    (inLast),
    .inValid   (inValid),
    .inReady   (inReady),
    .strobe    (strobe),
    .qNotEmpty (qNotEmpty),
    .outData   (outData),
    .outKeep   (outKeep),
    .outUser   (outUser),
    .outLast   (outLast)
  );
endmodule

// File: rtl/pkt_rr_checker.sv
module pkt_rr_checker
  import pkt_rr_pkg::*;
#(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned USER_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                outValid,
  input logic                outReady,
  input logic                outLast,
  input logic [DATA_W-1:0]   outData,
  input logic [DATA_W/8-1:0] outKeep,
  input logic [USER_W-1:0]   outUser,
  input logic [SEL_W-1:0]    sel,
  input logic [NUM_IN-1:0]   qNotEmpty
);
  logic selHasData, othersBusy, endBeat, midBeat;

  assign selHasData = |((qNotEmpty >> sel) & NUM_IN'(1));
  assign othersBusy = |(qNotEmpty & ~(NUM_IN'(1) << sel));
  assign endBeat    = outValid && outReady && outLast;
  assign midBeat    = outValid && outReady && !outLast;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outKeep)
                              && $stable(outUser) && $stable(outLast));

  // R3
  grant_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> selHasData);

  // R4
  pkt_atomic_chk: assert property (@(posedge clk) disable iff (!rstN)
    midBeat |=> sel == $past(sel));

  // R5
  rotate_away_chk: assert property (@(posedge clk) disable iff (!rstN)
    endBeat && othersBusy |=> outValid && sel != $past(sel));
endmodule

bind pkt_rr_arbiter pkt_rr_checker #(
  .NUM_IN(NUM_IN), .DATA_W(DATA_W), .USER_W(USER_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .outValid  (outValid),
  .outReady  (outReady),
  .outLast   (outLast),
  .outData   (outData),
  .outKeep   (outKeep),
  .outUser   (outUser),
  .sel       (strobe.sel),
  .qNotEmpty (qNotEmpty)
);

// File: tb/test_pkt_rr_arbiter.sv
module test_pkt_rr_arbiter;
  localparam int NI = 3, DW = 64, KW = 8, UW = 16, DEP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NI-1:0][DW-1:0] inData;
  logic [NI-1:0][KW-1:0] inKeep;
  logic [NI-1:0][UW-1:0] inUser;
  logic [NI-1:0]         inLast, inValid, inReady;
  logic [DW-1:0]         outData;
  logic [KW-1:0]         outKeep;
  logic [UW-1:0]         outUser;
  logic                  outLast, outValid, outReady;

  pkt_rr_arbiter #(.NUM_IN(NI), .DATA_W(DW), .USER_W(UW), .DEPTH(DEP)) i_pkt_rr_arbiter (
    .clk(clk), .rstN(rstN), .inData(inData), .inKeep(inKeep), .inUser(inUser),
    .inLast(inLast), .inValid(inValid), .inReady(inReady), .outData(outData),
    .outKeep(outKeep), .outUser(outUser), .outLast(outLast), .outValid(outValid),
    .outReady(outReady)
  );

  typedef struct packed {
    logic [DW-1:0] d;
    logic [KW-1:0] k;
    logic [UW-1:0] u;
    logic          l;
  } beat_t;

  beat_t srcQ[NI][$];
  beat_t mq[NI][$];
  int    mPtr = 0, mLock = 0;
  bit    mLocked = 0;
  int    errors = 0, checks = 0, pktId = 0;
  string tag = "R1";
  bit [NI-1:0] enMask = '0;
  bit    gapOn = 0;
  int    readyMode = 0;  // 0 always ready, 1 never, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  bit    stallPrev = 0, inPkt = 0;
  beat_t prevBeat;
  logic [1:0] curSrc = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic addPkt(input int s, input int len);
    for (int b = 0; b < len; b++) begin
      beat_t x;
      x.d = {8'(s), 24'(pktId), 32'(b * 7 + 1)};
      x.k = (b == len - 1) ? KW'((1 << ((pktId % KW) + 1)) - 1) : '1;
      x.u = {14'(pktId), 2'(s)};
      x.l = (b == len - 1);
      srcQ[s].push_back(x);
    end
    pktId++;
  endtask

  function automatic void predict(output bit v, output int sel);
    if (mLocked) begin
      sel = mLock;
      v   = (mq[sel].size() > 0);
    end else begin
      v = 0;
      sel = mPtr;
      for (int k = 0; k < NI; k++) begin
        int c = (mPtr + k) % NI;
        if (!v && mq[c].size() > 0) begin
          v = 1;
          sel = c;
        end
      end
    end
  endfunction

  task automatic cycle();
    bit ev;
    int es;
    bit rdy[NI];
    beat_t got;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < NI; i++) begin
      if (enMask[i] && srcQ[i].size() > 0 && (!gapOn || lfsr[i + 2])) begin
        inValid[i] = 1'b1;
        {inData[i], inKeep[i], inUser[i], inLast[i]} = srcQ[i][0];
      end else begin
        inValid[i] = 1'b0;
        {inData[i], inKeep[i], inUser[i], inLast[i]} = '0;
      end
    end
    outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? 1'b0 : lfsr[7];
    #1;
    predict(ev, es);
    for (int i = 0; i < NI; i++) begin
      rdy[i] = (mq[i].size() < DEP);
      check(inReady[i] == rdy[i], "R2", $sformatf("inReady[%0d]", i), 128'(inReady[i]), 128'(rdy[i]));
    end
    check(outValid == ev, tag, "outValid", 128'(outValid), 128'(ev));
    got = {outData, outKeep, outUser, outLast};
    if (ev && outValid) begin
      check(outUser == mq[es][0].u, tag, "outUser (source order)", 128'(outUser), 128'(mq[es][0].u));
      check({outData, outKeep, outLast} == {mq[es][0].d, mq[es][0].k, mq[es][0].l}, "R7",
            "data/keep/last", 128'({outData, outKeep, outLast}),
            128'({mq[es][0].d, mq[es][0].k, mq[es][0].l}));
    end
    if (stallPrev)
      check(outValid && got == prevBeat, "R6", "held beat", 128'({outValid, got}), 128'({1'b1, prevBeat}));
    if (outValid && outReady) begin
      if (inPkt) check(outUser[1:0] == curSrc, "R4", "source inside packet", 128'(outUser[1:0]), 128'(curSrc));
      inPkt  = !outLast;
      curSrc = outUser[1:0];
    end
    stallPrev = outValid && !outReady;
    prevBeat  = got;
    @(posedge clk);
    if (ev && outReady) begin
      bit wasLast = mq[es][0].l;
      void'(mq[es].pop_front());
      if (wasLast) begin
        mLocked = 0;
        mPtr = (es + 1) % NI;
      end else begin
        mLocked = 1;
        mLock = es;
      end
    end else if (ev) begin
      mLocked = 1;
      mLock = es;
    end
    for (int i = 0; i < NI; i++) begin
      if (inValid[i] && rdy[i]) begin
        mq[i].push_back(srcQ[i][0]);
        void'(srcQ[i].pop_front());
      end
    end
  endtask

  function automatic bit busy();
    for (int i = 0; i < NI; i++)
      if (srcQ[i].size() > 0 || mq[i].size() > 0) return 1;
    return 0;
  endfunction

  task automatic drain(input int maxc);
    int n = 0;
    while (busy() && n < maxc) begin
      cycle();
      n++;
    end
    check(!busy(), tag, "drain finished", 128'(n), 128'(maxc));
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL %s watchdog actual=running expected=finished", tag);
    summary();
    $finish;
  end

  initial begin
    inValid = '0; inData = '0; inKeep = '0; inUser = '0; inLast = '0; outReady = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    check(outValid == 1'b0 && inReady == '1, "R1", "state in reset",
          128'({outValid, inReady}), 128'({1'b0, 3'b111}));
    rstN = 1'b1;
    #1;
    // R1: first cycle after release
    check(outValid == 1'b0 && inReady == '1, "R1", "state after reset",
          128'({outValid, inReady}), 128'({1'b0, 3'b111}));
    repeat (2) cycle();

    // R8: single beat into an idle block
    tag = "R8"; enMask = 3'b010; readyMode = 0;
    addPkt(1, 1);
    cycle();
    cycle();
    check(mq[1].size() == 0, "R8", "beat left one cycle after entry", 128'(mq[1].size()), 128'(0));
    drain(20);

    // R5: all inputs busy, varied lengths, gaps
    tag = "R5"; enMask = 3'b111; gapOn = 1;
    for (int r = 0; r < 6; r++)
      for (int s = 0; s < NI; s++) addPkt(s, 1 + (r * 3 + s) % 5);
    drain(2000);

    // R3: middle input idle, rotation must skip it and wrap
    tag = "R3"; enMask = 3'b101; gapOn = 0;
    for (int r = 0; r < 5; r++) begin addPkt(0, 2 + r % 3); addPkt(2, 3); end
    drain(1000);

    // R6: random output stalls
    tag = "R6"; enMask = 3'b111; gapOn = 1; readyMode = 2;
    for (int r = 0; r < 8; r++)
      for (int s = 0; s < NI; s++) addPkt(s, 1 + (r + 2 * s) % 6);
    drain(4000);

    // R2: stalled output fills every queue
    tag = "R2"; gapOn = 0; readyMode = 1;
    for (int s = 0; s < NI; s++) for (int r = 0; r < 4; r++) addPkt(s, 8);
    repeat (30) cycle();
    check(inReady == '0, "R2", "all queues full", 128'(inReady), 128'(0));
    readyMode = 0;
    drain(2000);

    repeat (3) cycle();
    summary();
    $finish;
  end
endmodule